// File: doc/BRIEF.md
# Fractional Pixel Clock Generator

This block derives a pixel clock from one of two source clocks: a dedicated display clock and the internal bus clock. Each source arrives as a one-cycle tick on the block's fast system clock, one tick for every edge of that source, rising or falling, so all internal timing is counted in half input cycles. The division ratio is an unsigned fixed-point number with four fractional bits. A phase accumulator stretches an occasional output period by one input cycle, which makes the long-run average ratio exact.

Inside every output period, the rising and falling positions of the output level are set independently in half-cycle steps. A small write-only register port holds the source select, the divider and the edge positions. New divider and edge values take effect only when a new output period begins. A change of source is synchronised first and is applied only while the output is low. The outputs are the output level itself, a one-cycle strobe marking each rising edge, and a one-cycle pulse at the start of every output period.

Top module: `pclkgen_frac`

## Requirements
- R1: After reset the divider holds 0x10, the source select is 0 (bus clock), the rising position is 0 and the falling position is 1. While reset is held, `pix_clk`, `pix_ce` and `period_start` are all 0.
- R2: The divider (write address 1, bits 11:0) is a ratio D with four fractional bits. The output period averages D/16 input cycles, so over any 16 consecutive periods exactly 2·D source ticks occur.
- R3: Every output period is either N or N+1 input cycles long, where N = D[11:4], which is 2N or 2N+2 ticks. The number of longer periods in any 16 consecutive periods equals D[3:0].
- R4: With the display source selected, any divider below 0x10 behaves as 0x10, which divides by one.
- R5: With the bus source selected, any divider below 0x20 behaves as 0x20, so the output never exceeds half the bus rate.
- R6: The edge register (write address 2) holds the falling position in bits 24:16 and the rising position in bits 8:0, both counted in half input cycles from the start of the period. The level is 1 at position p exactly when rise ≤ p < fall.
- R7: Bit 20 of the general register (write address 0) selects the source: 1 selects the display ticks and 0 selects the bus ticks.
- R8: Divider and edge writes do not alter the output period already under way. They apply from the next period start.
- R9: A change of source select passes through a synchroniser. It is applied only while the output level is 0, and it restarts the period on the new source.
- R10: `period_start` pulses for one cycle in the cycle after the tick that opens a period. `pix_ce` pulses for one cycle in each cycle where `pix_clk` goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_bus | input | 1 | One pulse per edge of the bus source clock |
| tick_disp | input | 1 | One pulse per edge of the display source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 general, 1 divider, 2 edges |
| wr_data | input | 32 | Register write data |
| pix_clk | output | 1 | Output pixel clock level |
| pix_ce | output | 1 | One-cycle strobe on each rising edge of the output |
| period_start | output | 1 | One-cycle pulse at the start of each output period |

## Verification
On every cycle, the assertions check that:
- the period length never falls below the clamp floor of the selected source;
- the position counter stays inside the period;
- the output level and the period pulse move only on a source tick;
- the source switches only while the output is low;
- the rising strobe matches a real 0-to-1 transition.

Only the bench's scenarios can show that the average period is exact for each fractional ratio, that edges land at the programmed half-cycle positions, and that a write during a period leaves that period's length intact.

// File: rtl/pclkgen_pkg.sv
package pclkgen_pkg;
   typedef enum logic [1:0] {
      REG_GENERAL = 2'd0,
      REG_DIVIDER = 2'd1,
      REG_EDGES   = 2'd2,
      REG_NONE    = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/pclk_sync.sv
module pclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else if (i == 0) chain[i] <= d;
               else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pclk_regs.sv
module pclk_regs
   import pclkgen_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int DIV_W     = 12,
   parameter int FRAC_W    = 4,
   parameter int EDGE_W    = 9,
   parameter int SEL_BIT   = 20,
   parameter int FALL_LSB  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              sel_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [EDGE_W-1:0] rise_o,
   output logic [EDGE_W-1:0] fall_o
);
   localparam logic [DIV_W-1:0]  DIV_RST  = DIV_W'(1) << FRAC_W;
   localparam logic [EDGE_W-1:0] FALL_RST = EDGE_W'(1);

   reg_addr_e addr;
   logic      unused_wdata;

   assign addr         = reg_addr_e'(wr_addr);
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o  <= 1'b0;
         div_o  <= DIV_RST;
         rise_o <= '0;
         fall_o <= FALL_RST;
      end else if (wr_en) begin
         case (addr)
            REG_GENERAL: sel_o <= wr_data[SEL_BIT];
            REG_DIVIDER: div_o <= wr_data[DIV_W-1:0];
            REG_EDGES: begin
               rise_o <= wr_data[EDGE_W-1:0];
               fall_o <= wr_data[FALL_LSB +: EDGE_W];
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pclk_phase.sv
module pclk_phase #(
   parameter int INT_W  = 8,
   parameter int FRAC_W = 4,
   parameter int LEN_W  = INT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [INT_W-1:0]  int_part,
   input  logic [FRAC_W-1:0] frac_part,
   output logic [LEN_W-1:0]  len_o
);
   logic [FRAC_W-1:0] acc_q;
   logic [FRAC_W:0]   sum;
   logic              carry;

   assign sum   = {1'b0, acc_q} + {1'b0, frac_part};
   assign carry = sum[FRAC_W];
   assign len_o = LEN_W'({int_part, 1'b0}) + (carry ? LEN_W'(2) : LEN_W'(0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc_q <= '0;
      else if (step) acc_q <= sum[FRAC_W-1:0];
   end
endmodule

// File: rtl/pclk_wave.sv
module pclk_wave #(
   parameter int LEN_W  = 10,
   parameter int EDGE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              restart_req,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [EDGE_W-1:0] rise_in,
   input  logic [EDGE_W-1:0] fall_in,
   output logic              load_o,
   output logic              level_o,
   output logic              ce_o,
   output logic              ps_o,
   output logic [LEN_W-1:0]  pos_o,
   output logic [LEN_W-1:0]  len_o
);
   logic [LEN_W-1:0]  pos_q, len_q, nxt_pos;
   logic [EDGE_W-1:0] rise_q, fall_q, nxt_rise, nxt_fall;
   logic              restart_q, level_q, ce_q, ps_q, last, nxt_level;

   assign last     = restart_q || (pos_q == len_q - LEN_W'(1));
   assign load_o   = tick && last;
   assign nxt_pos  = last ? '0 : pos_q + LEN_W'(1);
   assign nxt_rise = last ? rise_in : rise_q;
   assign nxt_fall = last ? fall_in : fall_q;
   assign nxt_level = (nxt_pos >= LEN_W'(nxt_rise)) && (nxt_pos < LEN_W'(nxt_fall));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q     <= '0;
         len_q     <= LEN_W'(2);
         rise_q    <= '0;
         fall_q    <= EDGE_W'(1);
         restart_q <= 1'b1;
         level_q   <= 1'b0;
         ce_q      <= 1'b0;
         ps_q      <= 1'b0;
      end else begin
         ps_q <= load_o;
         ce_q <= tick && nxt_level && !level_q;
         if (restart_req)  restart_q <= 1'b1;
         else if (tick)    restart_q <= 1'b0;
         if (tick) begin
            pos_q   <= nxt_pos;
            level_q <= nxt_level;
            if (last) begin
               len_q  <= len_in;
               rise_q <= rise_in;
               fall_q <= fall_in;
            end
         end
      end
   end

   assign level_o = level_q;
   assign ce_o    = ce_q;
   assign ps_o    = ps_q;
   assign pos_o   = pos_q;
   assign len_o   = len_q;
endmodule

// File: rtl/pclkgen_frac.sv
module pclkgen_frac #(
   parameter int DATA_W        = 32,
   parameter int DIV_W         = 12,
   parameter int FRAC_W        = 4,
   parameter int EDGE_W        = 9,
   parameter int SEL_BIT       = 20,
   parameter int FALL_LSB      = 16,
   parameter int SYNC_STAGES   = 2,
   parameter int BUS_MIN_RATIO = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_bus,
   input  logic              tick_disp,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pix_clk,
   output logic              pix_ce,
   output logic              period_start
);
   localparam int INT_W = DIV_W - FRAC_W;
   localparam int LEN_W = INT_W + 2;
   localparam logic [DIV_W-1:0] MIN_DISP = DIV_W'(1) << FRAC_W;
   localparam logic [DIV_W-1:0] MIN_BUS  = DIV_W'(BUS_MIN_RATIO) << FRAC_W;

   generate
      if (FRAC_W < 1 || INT_W < 2) begin : g_bad_div
         $error("divider needs a fraction and at least two integer bits");
      end
      if (EDGE_W > LEN_W) begin : g_bad_edge
         $error("edge field wider than the period counter");
      end
      if (SEL_BIT >= DATA_W || FALL_LSB + EDGE_W > DATA_W || DIV_W > DATA_W) begin : g_bad_map
         $error("register field outside the data word");
      end
      if (BUS_MIN_RATIO < 1) begin : g_bad_bus
         $error("bus ratio floor must be at least one");
      end
   endgenerate

   logic              sel_reg, sel_sync, src_q, switch_now, tick_sel, load;
   logic [DIV_W-1:0]  div_reg, div_min, div_eff;
   logic [EDGE_W-1:0] rise_reg, fall_reg;
   logic [LEN_W-1:0]  len_next, pos_cur, len_cur;

   pclk_regs #(
      .DATA_W(DATA_W), .DIV_W(DIV_W), .FRAC_W(FRAC_W), .EDGE_W(EDGE_W),
      .SEL_BIT(SEL_BIT), .FALL_LSB(FALL_LSB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sel_o(sel_reg), .div_o(div_reg),
      .rise_o(rise_reg), .fall_o(fall_reg)
   );

   pclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sel_reg), .q(sel_sync)
   );

   assign switch_now = (sel_sync != src_q) && !pix_clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          src_q <= 1'b0;
      else if (switch_now) src_q <= sel_sync;
   end

   assign tick_sel = src_q ? tick_disp : tick_bus;
   assign div_min  = src_q ? MIN_DISP : MIN_BUS;
   assign div_eff  = (div_reg < div_min) ? div_min : div_reg;

   pclk_phase #(.INT_W(INT_W), .FRAC_W(FRAC_W), .LEN_W(LEN_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .step(load),
      .int_part(div_eff[DIV_W-1:FRAC_W]), .frac_part(div_eff[FRAC_W-1:0]),
      .len_o(len_next)
   );

   pclk_wave #(.LEN_W(LEN_W), .EDGE_W(EDGE_W)) u_wave (
      .clk(clk), .rst_n(rst_n), .tick(tick_sel), .restart_req(switch_now),
      .len_in(len_next), .rise_in(rise_reg), .fall_in(fall_reg),
      .load_o(load), .level_o(pix_clk), .ce_o(pix_ce), .ps_o(period_start),
      .pos_o(pos_cur), .len_o(len_cur)
   );
endmodule

// File: rtl/pclkgen_frac_chk.sv
module pclkgen_frac_chk #(
   parameter int LEN_W = 10,
   parameter int BUS_MIN_RATIO = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             src,
   input logic             level,
   input logic             ce,
   input logic             ps,
   input logic [LEN_W-1:0] pos,
   input logic [LEN_W-1:0] len
);
   // R4: no period is shorter than one display input cycle
   p_len_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
      len >= LEN_W'(2));

   // R5: a period loaded from the bus source is at least the bus floor
   p_bus_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ps && !$past(src)) |-> (len >= LEN_W'(2 * BUS_MIN_RATIO)));

   // R3: the position counter stays inside the current period
   p_pos_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pos < len);

   // R10: a period pulse follows a source tick
   p_ps_after_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ps |-> $past(tick));

   // R6: the level moves only on a source tick
   p_level_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (level != $past(level)) |-> $past(tick));

   // R9: the source changes only while the output is low
   p_switch_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src != $past(src)) |-> !$past(level));

   // R10: the strobe marks a real rising transition
   p_ce_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ce |-> (level && !$past(level)));
endmodule

bind pclkgen_frac pclkgen_frac_chk #(.LEN_W(LEN_W), .BUS_MIN_RATIO(BUS_MIN_RATIO)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick_sel), .src(src_q), .level(pix_clk),
   .ce(pix_ce), .ps(period_start), .pos(pos_cur), .len(len_cur)
);

// File: tb/pclkgen_frac_tb.sv
module pclkgen_frac_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_bus = 1'b0;
   logic        tick_disp = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pix_clk, pix_ce, period_start;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pclkgen_frac u_dut (
      .clk(clk), .rst_n(rst_n), .tick_bus(tick_bus), .tick_disp(tick_disp),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pix_clk(pix_clk), .pix_ce(pix_ce), .period_start(period_start)
   );

   // display edges every second cycle, bus edges every third cycle
   initial forever begin
      @(posedge clk); #1 tick_disp = 1'b1;
      @(posedge clk); #1 tick_disp = 1'b0;
   end
   initial forever begin
      @(posedge clk); #1 tick_bus = 1'b1;
      @(posedge clk); #1 tick_bus = 1'b0;
      @(posedge clk);
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(posedge clk); #1 wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1 wr_en = 1'b0;
   endtask

   task automatic wait_ps();
      do @(negedge clk); while (!period_start);
   endtask

   // counts source ticks and high half-cycle positions over nper periods
   task automatic measure(input bit disp, input int nper, output int ticks, output int highs);
      int  seen;
      bit  prev;
      wait_ps();
      ticks = 0; highs = 0; seen = 0; prev = 1'b0;
      while (seen < nper) begin
         @(negedge clk);
         if (prev && pix_clk) highs++;
         prev = disp ? tick_disp : tick_bus;
         if (prev) ticks++;
         if (period_start) seen++;
      end
   endtask

   task automatic count_to_ps(input bit disp, output int ticks);
      ticks = 0;
      do begin
         @(negedge clk);
         if (disp ? tick_disp : tick_bus) ticks++;
      end while (!period_start);
   endtask

   task automatic ratio_case(input string req, input int dv, input int fall,
                             input int exp_t, input int exp_h);
      int t, h;
      wr(2'd1, 32'(dv));
      wr(2'd2, 32'(fall) << 16);
      measure(1'b1, 3, t, h);
      measure(1'b1, 16, t, h);
      check(req, t, exp_t);
      check({req, " duty"}, h, exp_h);
   endtask

   initial begin
      int t, h;
      // R1: outputs quiet during reset
      repeat (4) @(negedge clk);
      check("R1 level in reset", int'(pix_clk), 0);
      check("R1 period pulse in reset", int'(period_start), 0);
      check("R1 strobe in reset", int'(pix_ce), 0);
      @(posedge clk); #1 rst_n = 1'b1;

      // R1 R5: default 0x10 on bus clamps to 0x20, fall=1 gives one high half
      measure(1'b0, 16, t, h);
      check("R1 R5 default bus ticks", t, 64);
      check("R1 R6 default duty", h, 16);

      // R7 R9: select display via bit 20
      wr(2'd0, 32'h0010_0000);
      ratio_case("R2 R7 R9 div 0x10", 16'h10, 1, 32, 16);
      ratio_case("R3 div 0x18", 16'h18, 1, 48, 16);
      ratio_case("R3 div 0x25", 16'h25, 2, 74, 32);
      ratio_case("R2 div 0x40", 16'h40, 4, 128, 64);
      ratio_case("R4 clamp 0x05", 16'h05, 1, 32, 16);
      ratio_case("R4 clamp 0x00", 16'h00, 1, 32, 16);

      // R6 R10: rise at 3, fall at 7 in an 8-half period
      wr(2'd1, 32'h40);
      wr(2'd2, (32'd7 << 16) | 32'd3);
      measure(1'b1, 3, t, h);
      measure(1'b1, 16, t, h);
      check("R6 windowed duty", h, 64);
      wait_ps();
      t = 0;
      do begin
         @(negedge clk);
         if (tick_disp) t++;
      end while (!pix_ce);
      check("R10 rise offset ticks", t, 3);
      // R6: fall beyond the period keeps level high from rise 0
      wr(2'd2, 32'h01FF_0000);
      measure(1'b1, 3, t, h);
      measure(1'b1, 16, t, h);
      check("R6 fall past end", h, 128);

      // R8: write during a period leaves that period unchanged
      wait_ps();
      fork
         wr(2'd1, 32'h10);
         count_to_ps(1'b1, t);
      join
      check("R8 period during write", t, 8);
      count_to_ps(1'b1, t);
      check("R8 next period uses new divider", t, 2);

      // R5 R7 R9: back to bus source
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h30);
      wr(2'd2, 32'h0003_0000);
      measure(1'b0, 3, t, h);
      measure(1'b0, 16, t, h);
      check("R5 R7 R9 bus div 0x30", t, 96);
      check("R6 bus duty", h, 48);
      wr(2'd1, 32'h18);
      measure(1'b0, 3, t, h);
      measure(1'b0, 16, t, h);
      check("R5 bus clamp 0x18", t, 64);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule